// File: doc/BRIEF.md
# Burst Column Sequencer

This block generates the ordered column addresses for one burst access to a synchronous DRAM bank. A `start` pulse loads a starting column together with the programmed burst length, the ordering (sequential or interleave), the direction of the access and a flag that selects single-word write bursts. From the next cycle on, the block presents one column per cycle on `col_out` with `col_valid` high. It steps to the following column in every cycle where `advance` is high, and it raises `col_last` on the final column of a finite burst.

The ordering stays inside an aligned block whose size is the burst length. In sequential order the low bits count up from the start and wrap to zero inside that block, and the upper column bits stay fixed. In interleave order the low bits are the start column XORed with the beat index. A full-page burst counts through the entire row, wraps from the top column to zero and runs until a `stop` or a new `start`. Data masking is applied outside this block, and `advance` is the only signal that paces it.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `col_valid` and `col_last` are 0.
- R2: One cycle after `start`, `col_valid` is 1 and `col_out` equals the `start_col` value given with `start`. `start` takes precedence over `stop` and over any burst already running.
- R3: Sequential order with burst length L (2, 4 or 8): beat k gives the aligned L-block of the start column plus ((start mod L) + k) mod L, so the upper column bits never change.
- R4: Interleave order with burst length L: beat k gives the start column with its low log2(L) bits XORed with k. For example, length 8 from 5 gives 5,4,7,6,1,0,3,2.
- R5: Full page (code 7) steps by one through all 2^COL_W columns, wraps from the top column to 0, keeps running until `stop` or `start`, and never raises `col_last`.
- R6: If interleave is requested together with full page, the burst uses sequential order.
- R7: The burst length is taken from `len_code`: 0 means 1, 1 means 2, 2 means 4, 3 means 8 and 7 means full page. The codes 4, 5 and 6 act as length 1.
- R8: `col_last` is 1 exactly on the final column of a finite burst. If `advance` is high while `col_last` is high, `col_valid` is 0 in the next cycle.
- R9: `stop` during a burst (without `start`) makes `col_valid` 0 in the next cycle.
- R10: When `single_wr` is 1, a burst started with `is_write` is one column long. A read burst under the same setting keeps its programmed length. When `single_wr` is 0, a write burst uses the programmed length.
- R11: In a cycle with `advance` low (and neither `start` nor `stop`), `col_out`, `col_valid` and `col_last` hold their values. Each cycle with `advance` high steps exactly one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load a new burst |
| start_col | input | COL_W | First column of the burst |
| len_code | input | 3 | Burst length code |
| interleave | input | 1 | 1 selects interleave order |
| is_write | input | 1 | The burst is a write |
| single_wr | input | 1 | Write bursts are forced to one column |
| advance | input | 1 | Step to the next column |
| stop | input | 1 | End the burst at once |
| col_out | output | COL_W | Current column |
| col_valid | output | 1 | `col_out` holds a burst column |
| col_last | output | 1 | Final column of a finite burst |

## Verification
The properties assume that `start` is a single-cycle pulse, that its configuration inputs are valid in the same cycle, and that `advance` and `stop` have meaning only while a burst runs. The stimulus drives all inputs at the falling edge. It holds the configuration only during `start` cycles and overlaps `stop` with `start` once, on purpose, to check precedence. A behavioural model computes the column from its arithmetic definition with integer operations, and the bench compares the outputs against that model on every cycle.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam logic [2:0] BL_ONE   = 3'd0;
  localparam logic [2:0] BL_TWO   = 3'd1;
  localparam logic [2:0] BL_FOUR  = 3'd2;
  localparam logic [2:0] BL_EIGHT = 3'd3;
  localparam logic [2:0] BL_PAGE  = 3'd7;

  typedef enum logic {ORD_SEQ = 1'b0, ORD_XOR = 1'b1} order_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [2:0]       len_code,
  input  logic             il_req,
  input  logic             is_write,
  input  logic             single_wr,
  output logic [COL_W-1:0] span_mask,
  output order_e           order,
  output logic             page
);
  logic [COL_W-1:0] raw_mask;
  logic             raw_page;

  always_comb begin
    raw_page = 1'b0;
    case (len_code)
      BL_TWO:   raw_mask = COL_W'(1);
      BL_FOUR:  raw_mask = COL_W'(3);
      BL_EIGHT: raw_mask = COL_W'(7);
      BL_PAGE: begin
        raw_mask = '1;
        raw_page = 1'b1;
      end
      default:  raw_mask = '0;
    endcase
  end

  always_comb begin
    if (is_write && single_wr) begin
      span_mask = '0;
      page      = 1'b0;
    end else begin
      span_mask = raw_mask;
      page      = raw_page;
    end
    order = (il_req && !page) ? ORD_XOR : ORD_SEQ;
  end
endmodule

// File: rtl/burst_col_calc.sv
module burst_col_calc
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] span_mask,
  input  order_e           order,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] xor_col;
  logic [COL_W-1:0] sum;

  always_comb begin
    sum     = base + beat;
    seq_col = (base & ~span_mask) | (sum & span_mask);
    xor_col = base ^ (beat & span_mask);
    col     = (order == ORD_XOR) ? xor_col : seq_col;
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             interleave,
  input  logic             is_write,
  input  logic             single_wr,
  input  logic             advance,
  input  logic             stop,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             col_last
);
  logic [COL_W-1:0] dec_mask;
  order_e           dec_order;
  logic             dec_page;

  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  order_e           order_q;
  logic             page_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] beat_n;
  logic [COL_W-1:0] col_n;
  logic             valid_q;
  logic             last_q;
  logic [COL_W-1:0] col_q;

  burst_len_decode #(.COL_W(COL_W)) u_dec (
    .len_code  (len_code),
    .il_req    (interleave),
    .is_write  (is_write),
    .single_wr (single_wr),
    .span_mask (dec_mask),
    .order     (dec_order),
    .page      (dec_page)
  );

  assign beat_n = beat_q + COL_W'(1);

  burst_col_calc #(.COL_W(COL_W)) u_calc (
    .base      (base_q),
    .beat      (beat_n),
    .span_mask (mask_q),
    .order     (order_q),
    .col       (col_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      base_q  <= '0;
      mask_q  <= '0;
      order_q <= ORD_SEQ;
      page_q  <= 1'b0;
      beat_q  <= '0;
      col_q   <= '0;
    end else if (start) begin
      valid_q <= 1'b1;
      last_q  <= !dec_page && (dec_mask == '0);
      base_q  <= start_col;
      mask_q  <= dec_mask;
      order_q <= dec_order;
      page_q  <= dec_page;
      beat_q  <= '0;
      col_q   <= start_col;
    end else if (valid_q && stop) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (valid_q && advance) begin
      if (last_q) begin
        valid_q <= 1'b0;
        last_q  <= 1'b0;
      end else begin
        beat_q <= beat_n;
        col_q  <= col_n;
        last_q <= !page_q && (beat_n == mask_q);
      end
    end
  end

  assign col_out   = col_q;
  assign col_valid = valid_q;
  assign col_last  = last_q;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic [2:0]       len_code,
  input logic             is_write,
  input logic             single_wr,
  input logic             advance,
  input logic             stop,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             col_last
);
  a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
    start |=> col_valid && col_out == $past(start_col));

  a_r7_len_one: assert property (@(posedge clk) disable iff (rst)
    start && len_code == 3'd0 |=> col_last);

  a_r5_page_no_last: assert property (@(posedge clk) disable iff (rst)
    start && len_code == 3'd7 && !(is_write && single_wr) |=> !col_last);

  a_r10_single_write: assert property (@(posedge clk) disable iff (rst)
    start && is_write && single_wr |=> col_last);

  a_r8_last_needs_valid: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_valid);

  a_r8_end_after_last: assert property (@(posedge clk) disable iff (rst)
    col_valid && col_last && advance && !start && !stop |=> !col_valid);

  a_r9_stop_ends: assert property (@(posedge clk) disable iff (rst)
    col_valid && stop && !start |=> !col_valid);

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    col_valid && !advance && !stop && !start
      |=> col_valid && $stable(col_out) && $stable(col_last));
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .start_col (start_col),
  .len_code  (len_code),
  .is_write  (is_write),
  .single_wr (single_wr),
  .advance   (advance),
  .stop      (stop),
  .col_out   (col_out),
  .col_valid (col_valid),
  .col_last  (col_last)
);

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;
  localparam int COL_W = 10;
  localparam int NCOL  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       len_code = '0;
  logic             interleave = 1'b0;
  logic             is_write = 1'b0;
  logic             single_wr = 1'b0;
  logic             advance = 1'b0;
  logic             stop = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             col_valid;
  logic             col_last;

  always #4 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) dut (.*);

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  bit    done     = 0;

  // behavioural reference
  int m_valid = 0, m_base = 0, m_len = 1, m_il = 0, m_idx = 0;

  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 0;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) m_valid = 0;
    else if (start) begin
      m_len = len_of(len_code);
      if (is_write && single_wr) m_len = 1;
      m_il    = (interleave && m_len != 0) ? 1 : 0;
      m_base  = int'(start_col);
      m_idx   = 0;
      m_valid = 1;
    end else if (m_valid != 0 && stop) m_valid = 0;
    else if (m_valid != 0 && advance) begin
      if (m_len != 0 && m_idx == m_len - 1) m_valid = 0;
      else m_idx = m_idx + 1;
    end
  end

  function automatic int exp_col();
    int off, blk;
    if (m_len == 0) return (m_base + m_idx) % NCOL;
    off = m_base % m_len;
    blk = m_base - off;
    if (m_il != 0) return blk + (off ^ m_idx);
    return blk + ((off + m_idx) % m_len);
  endfunction

  task automatic compare();
    int e_last;
    e_last = (m_valid != 0 && m_len != 0 && m_idx == m_len - 1) ? 1 : 0;
    n_checks++;
    if (int'(col_valid) != m_valid) begin
      n_fail++;
      $display("FAIL %s col_valid actual %0d expected %0d", cur_req, col_valid, m_valid);
    end
    n_checks++;
    if (int'(col_last) != e_last) begin
      n_fail++;
      $display("FAIL %s col_last actual %0d expected %0d", cur_req, col_last, e_last);
    end
    if (m_valid != 0) begin
      n_checks++;
      if (int'(col_out) != exp_col()) begin
        n_fail++;
        $display("FAIL %s col_out actual %0d expected %0d", cur_req, col_out, exp_col());
      end
    end
  endtask

  task automatic cyc(input logic adv, input logic stp);
    @(negedge clk);
    compare();
    start = 1'b0; advance = adv; stop = stp;
  endtask

  task automatic go(input int col, input logic [2:0] lc, input logic il,
                    input logic wr, input logic sw, input logic stp);
    @(negedge clk);
    compare();
    start = 1'b1; start_col = COL_W'(col); len_code = lc; interleave = il;
    is_write = wr; single_wr = sw; advance = 1'b0; stop = stp;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired, actual running expected finished");
    finish_up();
  end

  initial begin
    cur_req = "R1";
    repeat (3) cyc(1'b0, 1'b0);
    rst = 1'b0;
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0);

    cur_req = "R3";            // sequential, length 8, wraps in block
    go(10'h3F5, 3'd3, 0, 0, 0, 0); run(10);
    go(2, 3'd2, 0, 0, 0, 0);  run(6);
    go(9, 3'd1, 0, 0, 0, 0);  run(4);

    cur_req = "R4";            // interleave ordering
    go(5, 3'd3, 1, 0, 0, 0);  run(10);
    go(3, 3'd2, 1, 0, 0, 0);  run(6);
    go(10'h2AB, 3'd1, 1, 0, 0, 0); run(3);

    cur_req = "R7";            // length codes 0 and reserved
    go(77, 3'd0, 0, 0, 0, 0); run(2);
    go(78, 3'd5, 1, 0, 0, 0); run(2);
    go(79, 3'd4, 0, 0, 0, 0); run(2);

    cur_req = "R8";            // last then drop, finite length 4
    go(12, 3'd2, 0, 0, 0, 0); run(5);

    cur_req = "R11";           // advance low holds
    go(6, 3'd3, 1, 0, 0, 0);
    for (int i = 0; i < 16; i++) cyc((i % 3) != 1, 1'b0);
    run(4);

    cur_req = "R5";            // full page wrap
    go(1020, 3'd7, 0, 0, 0, 0); run(12);
    cur_req = "R9";
    cyc(1'b1, 1'b1); cyc(1'b0, 1'b0); cyc(1'b1, 1'b0);
    go(40, 3'd3, 0, 0, 0, 0); run(3); cyc(1'b0, 1'b1); run(2);

    cur_req = "R6";            // interleave ignored on full page
    go(1022, 3'd7, 1, 0, 0, 0); run(6);
    cur_req = "R2";            // new start interrupts, beats stop
    go(300, 3'd2, 0, 0, 0, 1); run(2);
    go(500, 3'd3, 1, 0, 0, 0); run(9);

    cur_req = "R10";           // single-write mode
    go(17, 3'd3, 0, 1, 1, 0); run(3);
    go(17, 3'd3, 0, 0, 1, 0); run(9);
    go(17, 3'd3, 0, 1, 0, 0); run(9);
    go(33, 3'd7, 0, 1, 1, 0); run(3);

    cyc(1'b0, 1'b0);
    finish_up();
  end
endmodule